// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a small multi-cycle processor with separate instruction and data memories. The processor has 16-bit instructions, 8-bit data and eight 8-bit general registers. The unit steps through a fetch phase, a decode phase, and then one or two phases chosen by the 4-bit opcode. These phases cover ALU operations, loading an immediate value, loads through a register or through a direct address, direct stores, branches on the zero or carry flag, absolute jumps and jumps through a register. The datapath, the memories and the ALU are outside this block.

Every output is a function of the registered phase alone, so the outputs are Moore outputs. The opcode and the two flags are sampled on the clock edge that ends the decode phase. The ALU function is the low three bits of the opcode. It is captured on that same edge, so the execute phase drives it from a register and not from the live opcode input. Every phase assigns every output. A control word with all fields at zero stands for the don't-care settings.

Top module: `mcyc_ctrl_fsm`

## Requirements
- R1: While the active-high reset `rst` is 1, the unit is in the fetch phase and shows the fetch control word at once, without waiting for a clock edge. This holds even when reset arrives in the middle of an instruction.
- R2: In the fetch phase the outputs are as follows.
  - `mem_rd`, `ir_ld` and `pc_wr` are 1.
  - `mem_wr`, `reg_wr` and `flag_wr` are 0.
  - `addr_sel` is 0 (PC), `alu_a_sel` is 0 (PC) and `alu_b_sel` is 1 (constant step).
  - `alu_op` is 0 (add), `pc_src` is 0 (ALU result) and `wb_src` is 0.
- R3: Opcodes 0 to 6 are ALU operations and take four phases: fetch, decode, execute, write-back. In execute, `alu_a_sel` is 1 (register), `alu_b_sel` is 0 (register), `alu_op` equals opcode bits [2:0] and `flag_wr` is 1. In write-back, `reg_wr` is 1 and `wb_src` is 0 (ALU). The unit then returns to fetch.
- R4: In the decode phase every output is 0.
- R5: Opcode 7 (load immediate) is followed, after decode, by one write-back phase with `reg_wr` set to 1 and `wb_src` set to 2 (immediate).
- R6: Opcode 8 (load through register) runs a memory phase with `mem_rd` set to 1 and `addr_sel` set to 1 (register). It then runs a write-back phase with `reg_wr` set to 1 and `wb_src` set to 1 (memory data).
- R7: Opcode 9 (direct load) runs a memory phase with `mem_rd` set to 1 and `addr_sel` set to 2 (instruction address field). It then runs the same write-back phase as R6.
- R8: Opcode 10 (direct store) runs one phase with `mem_wr` set to 1 and `addr_sel` set to 2, and then returns straight to fetch without writing a register.
- R9: Opcode 11 branches on the zero flag and opcode 12 branches on the carry flag. The selected flag is sampled at the end of decode. When it is 1, a branch phase follows with `pc_wr` 1, `alu_a_sel` 0, `alu_b_sel` 2 (offset), `alu_op` 0 and `pc_src` 0. When it is 0, the unit goes back to fetch. The other flag has no effect.
- R10: Opcode 13 runs one phase with `pc_wr` 1 and `pc_src` 1 (instruction address field). Opcode 14 runs one phase with `pc_wr` 1 and `pc_src` 2 (register).
- R11: Opcode 15 is not assigned. After decode, the unit returns to fetch and asserts no write strobe.
- R12: `mem_rd` and `mem_wr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| opcode | input | 4 | Opcode field, instruction bits [15:12] |
| zero_flag | input | 1 | Zero flag from the ALU |
| carry_flag | input | 1 | Carry or borrow flag from the ALU |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| ir_ld | output | 1 | Load the instruction register |
| pc_wr | output | 1 | Write the program counter |
| reg_wr | output | 1 | Write the register file |
| flag_wr | output | 1 | Update the zero and carry flags |
| addr_sel | output | 2 | Memory address source: 0 PC, 1 register, 2 instruction field |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register |
| alu_b_sel | output | 2 | ALU B operand: 0 register, 1 step, 2 offset |
| alu_op | output | 3 | ALU function: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 and, 5 or, 6 xor |
| pc_src | output | 2 | PC source: 0 ALU, 1 instruction field, 2 register |
| wb_src | output | 2 | Register write data: 0 ALU, 1 memory, 2 immediate |

## Verification
Each control word is a Moore output. It appears just after the rising edge that enters its phase and stays fixed for the whole cycle. For an instruction started in fetch, the decode word is due one edge later and the opcode-dependent words are due from the second edge on. The reset word appears as soon as `rst` rises. For each instruction, the bench queues one expected word per cycle and gives the opcode and flags at the start of fetch. A monitor pops one queued word at every falling edge, so each word is compared in the middle of the cycle it belongs to. The reset checks are made shortly after `rst` rises, before any clock edge.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W  = 4;
    localparam int ALUF_W = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [3:0] {
        PH_FETCH    = 4'd0,
        PH_DECODE   = 4'd1,
        PH_ALU_EXEC = 4'd2,
        PH_ALU_WB   = 4'd3,
        PH_IMM_WB   = 4'd4,
        PH_LD_IND   = 4'd5,
        PH_LD_DIR   = 4'd6,
        PH_LD_WB    = 4'd7,
        PH_STORE    = 4'd8,
        PH_BR_TAKE  = 4'd9,
        PH_JMP_ABS  = 4'd10,
        PH_JMP_REG  = 4'd11
    } phase_e;

    // opcode values; 0..6 are ALU operations
    localparam logic [OPC_W-1:0] OP_LDI  = 4'd7;
    localparam logic [OPC_W-1:0] OP_LDR  = 4'd8;
    localparam logic [OPC_W-1:0] OP_LDD  = 4'd9;
    localparam logic [OPC_W-1:0] OP_STD  = 4'd10;
    localparam logic [OPC_W-1:0] OP_BRZ  = 4'd11;
    localparam logic [OPC_W-1:0] OP_BRC  = 4'd12;
    localparam logic [OPC_W-1:0] OP_JMP  = 4'd13;
    localparam logic [OPC_W-1:0] OP_JMPR = 4'd14;

    localparam logic [ALUF_W-1:0] ALUF_ADD = 3'd0;

    localparam logic [SEL_W-1:0] ADDR_PC    = 2'd0;
    localparam logic [SEL_W-1:0] ADDR_REG   = 2'd1;
    localparam logic [SEL_W-1:0] ADDR_FIELD = 2'd2;

    localparam logic A_PC  = 1'b0;
    localparam logic A_REG = 1'b1;

    localparam logic [SEL_W-1:0] B_REG  = 2'd0;
    localparam logic [SEL_W-1:0] B_STEP = 2'd1;
    localparam logic [SEL_W-1:0] B_OFFS = 2'd2;

    localparam logic [SEL_W-1:0] PCS_ALU   = 2'd0;
    localparam logic [SEL_W-1:0] PCS_FIELD = 2'd1;
    localparam logic [SEL_W-1:0] PCS_REG   = 2'd2;

    localparam logic [SEL_W-1:0] WB_ALU = 2'd0;
    localparam logic [SEL_W-1:0] WB_MEM = 2'd1;
    localparam logic [SEL_W-1:0] WB_IMM = 2'd2;

    typedef struct packed {
        phase_e              ph;
        logic [ALUF_W-1:0]   aluf;
    } seq_t;

    typedef struct packed {
        logic                mem_rd;
        logic                mem_wr;
        logic                ir_ld;
        logic                pc_wr;
        logic                reg_wr;
        logic                flag_wr;
        logic [SEL_W-1:0]    addr_sel;
        logic                alu_a_sel;
        logic [SEL_W-1:0]    alu_b_sel;
        logic [ALUF_W-1:0]   alu_op;
        logic [SEL_W-1:0]    pc_src;
        logic [SEL_W-1:0]    wb_src;
    } ctrl_t;

endpackage

// File: rtl/mcc_next_phase.sv
module mcc_next_phase
    import mcc_pkg::*;
(
    input  seq_t               cur,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               zero_flag,
    input  logic               carry_flag,
    output seq_t               nxt
);

    always_comb begin
        nxt.ph   = PH_FETCH;
        nxt.aluf = cur.aluf;
        case (cur.ph)
            PH_FETCH: nxt.ph = PH_DECODE;
            PH_DECODE: begin
                nxt.aluf = opcode[ALUF_W-1:0];
                if (opcode < OP_LDI) begin
                    nxt.ph = PH_ALU_EXEC;
                end else begin
                    case (opcode)
                        OP_LDI:  nxt.ph = PH_IMM_WB;
                        OP_LDR:  nxt.ph = PH_LD_IND;
                        OP_LDD:  nxt.ph = PH_LD_DIR;
                        OP_STD:  nxt.ph = PH_STORE;
                        OP_BRZ:  nxt.ph = zero_flag  ? PH_BR_TAKE : PH_FETCH;
                        OP_BRC:  nxt.ph = carry_flag ? PH_BR_TAKE : PH_FETCH;
                        OP_JMP:  nxt.ph = PH_JMP_ABS;
                        OP_JMPR: nxt.ph = PH_JMP_REG;
                        default: nxt.ph = PH_FETCH;
                    endcase
                end
            end
            PH_ALU_EXEC: nxt.ph = PH_ALU_WB;
            PH_LD_IND:   nxt.ph = PH_LD_WB;
            PH_LD_DIR:   nxt.ph = PH_LD_WB;
            // write-back, store, branch, jumps and unused codes all re-enter fetch
            default:     nxt.ph = PH_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
(
    input  seq_t   cur,
    output ctrl_t  ctl
);

    always_comb begin
        ctl = '0;   // every field has a value in every phase; zero stands for don't care
        case (cur.ph)
            PH_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_ld     = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.addr_sel  = ADDR_PC;
                ctl.alu_a_sel = A_PC;
                ctl.alu_b_sel = B_STEP;
                ctl.alu_op    = ALUF_ADD;
                ctl.pc_src    = PCS_ALU;
            end
            PH_ALU_EXEC: begin
                ctl.alu_a_sel = A_REG;
                ctl.alu_b_sel = B_REG;
                ctl.alu_op    = cur.aluf;
                ctl.flag_wr   = 1'b1;
            end
            PH_ALU_WB: begin
                ctl.reg_wr = 1'b1;
                ctl.wb_src = WB_ALU;
            end
            PH_IMM_WB: begin
                ctl.reg_wr = 1'b1;
                ctl.wb_src = WB_IMM;
            end
            PH_LD_IND: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = ADDR_REG;
            end
            PH_LD_DIR: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = ADDR_FIELD;
            end
            PH_LD_WB: begin
                ctl.reg_wr = 1'b1;
                ctl.wb_src = WB_MEM;
            end
            PH_STORE: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = ADDR_FIELD;
            end
            PH_BR_TAKE: begin
                ctl.pc_wr     = 1'b1;
                ctl.alu_a_sel = A_PC;
                ctl.alu_b_sel = B_OFFS;
                ctl.alu_op    = ALUF_ADD;
                ctl.pc_src    = PCS_ALU;
            end
            PH_JMP_ABS: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PCS_FIELD;
            end
            PH_JMP_REG: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PCS_REG;
            end
            default: ctl = '0;   // decode and unused codes
        endcase
    end

endmodule

// File: rtl/mcyc_ctrl_fsm.sv
module mcyc_ctrl_fsm
    import mcc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               zero_flag,
    input  logic               carry_flag,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               ir_ld,
    output logic               pc_wr,
    output logic               reg_wr,
    output logic               flag_wr,
    output logic [SEL_W-1:0]   addr_sel,
    output logic               alu_a_sel,
    output logic [SEL_W-1:0]   alu_b_sel,
    output logic [ALUF_W-1:0]  alu_op,
    output logic [SEL_W-1:0]   pc_src,
    output logic [SEL_W-1:0]   wb_src
);

    seq_t  seq_d;
    seq_t  seq_q;
    ctrl_t ctl;

    mcc_next_phase u_next (
        .cur        (seq_q),
        .opcode     (opcode),
        .zero_flag  (zero_flag),
        .carry_flag (carry_flag),
        .nxt        (seq_d)
    );

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            seq_q <= '{ph: PH_FETCH, aluf: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    mcc_out_decode u_out (
        .cur (seq_q),
        .ctl (ctl)
    );

    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign ir_ld     = ctl.ir_ld;
    assign pc_wr     = ctl.pc_wr;
    assign reg_wr    = ctl.reg_wr;
    assign flag_wr   = ctl.flag_wr;
    assign addr_sel  = ctl.addr_sel;
    assign alu_a_sel = ctl.alu_a_sel;
    assign alu_b_sel = ctl.alu_b_sel;
    assign alu_op    = ctl.alu_op;
    assign pc_src    = ctl.pc_src;
    assign wb_src    = ctl.wb_src;

    // a memory cycle is either a read or a write
    assert_excl_rw_R12: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // the fetch word lasts one cycle and is followed by the all-quiet decode word
    assert_fetch_then_decode_R4: assert property (@(posedge clk) disable iff (rst)
        ir_ld |=> (!ir_ld && !mem_rd && !mem_wr && !pc_wr && !reg_wr && !flag_wr));

    // every register write-back phase is the last of its instruction
    assert_wb_returns_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> ir_ld);

    // the store phase hands over straight to fetch
    assert_store_returns_R8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_ld);

    // a PC update outside fetch (branch or jump) ends the instruction
    assert_pc_phase_returns_R9: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && !ir_ld) |=> ir_ld);

    // the execute phase always leads into ALU write-back
    assert_exec_then_wb_R3: assert property (@(posedge clk) disable iff (rst)
        flag_wr |=> (reg_wr && wb_src == WB_ALU));

endmodule

// File: tb/mcyc_ctrl_fsm_test.sv
`timescale 1ns/1ps
module mcyc_ctrl_fsm_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst;
    logic [3:0] opcode;
    logic       zero_flag;
    logic       carry_flag;
    logic       mem_rd, mem_wr, ir_ld, pc_wr, reg_wr, flag_wr, alu_a_sel;
    logic [1:0] addr_sel, alu_b_sel, pc_src, wb_src;
    logic [2:0] alu_op;

    mcyc_ctrl_fsm uut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .zero_flag(zero_flag), .carry_flag(carry_flag),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld), .pc_wr(pc_wr),
        .reg_wr(reg_wr), .flag_wr(flag_wr), .addr_sel(addr_sel),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .pc_src(pc_src), .wb_src(wb_src)
    );

    // word layout: strobes {rd,wr,ir,pc,reg,flag}, addr, a, b, op, pc_src, wb
    wire [17:0] act = {mem_rd, mem_wr, ir_ld, pc_wr, reg_wr, flag_wr,
                       addr_sel, alu_a_sel, alu_b_sel, alu_op, pc_src, wb_src};

    localparam logic [17:0] V_FETCH = {6'b101100, 2'd0, 1'b0, 2'd1, 3'd0, 2'd0, 2'd0};
    localparam logic [17:0] V_DEC   = 18'd0;
    localparam logic [17:0] V_AWB   = {6'b000010, 2'd0, 1'b0, 2'd0, 3'd0, 2'd0, 2'd0};
    localparam logic [17:0] V_IWB   = {6'b000010, 2'd0, 1'b0, 2'd0, 3'd0, 2'd0, 2'd2};
    localparam logic [17:0] V_LDR   = {6'b100000, 2'd1, 1'b0, 2'd0, 3'd0, 2'd0, 2'd0};
    localparam logic [17:0] V_LDD   = {6'b100000, 2'd2, 1'b0, 2'd0, 3'd0, 2'd0, 2'd0};
    localparam logic [17:0] V_LWB   = {6'b000010, 2'd0, 1'b0, 2'd0, 3'd0, 2'd0, 2'd1};
    localparam logic [17:0] V_ST    = {6'b010000, 2'd2, 1'b0, 2'd0, 3'd0, 2'd0, 2'd0};
    localparam logic [17:0] V_BR    = {6'b000100, 2'd0, 1'b0, 2'd2, 3'd0, 2'd0, 2'd0};
    localparam logic [17:0] V_JA    = {6'b000100, 2'd0, 1'b0, 2'd0, 3'd0, 2'd1, 2'd0};
    localparam logic [17:0] V_JR    = {6'b000100, 2'd0, 1'b0, 2'd0, 3'd0, 2'd2, 2'd0};

    function automatic logic [17:0] v_exec(input logic [2:0] f);
        return {6'b000001, 2'd0, 1'b1, 2'd0, f, 2'd0, 2'd0};
    endfunction

    int checks = 0;
    int fails  = 0;
    logic [17:0] exp_q[$];
    string       tag_q[$];
    string       fetch_tag = "R2";

    task automatic check_word(input logic [17:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(input logic [17:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // monitor: one expected word per cycle, compared mid-cycle
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            logic [17:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check_word(e, t);
            checks++;
            if (mem_rd && mem_wr) begin
                fails++;
                $display("FAIL R12 actual=rd%0b_wr%0b expected=not_both", mem_rd, mem_wr);
            end
        end
    end

    // driver: called just after an edge that entered fetch
    task automatic run_instr(input logic [3:0] op, input logic z, input logic c);
        int n;
        string next_tag;
        next_tag = "R2";
        push(V_FETCH, fetch_tag);
        push(V_DEC, "R4");
        n = 2;
        if (op <= 4'd6) begin
            push(v_exec(op[2:0]), "R3");
            push(V_AWB, "R3");
            n += 2;
        end else begin
            case (op)
                4'd7:  begin push(V_IWB, "R5"); n += 1; end
                4'd8:  begin push(V_LDR, "R6"); push(V_LWB, "R6"); n += 2; end
                4'd9:  begin push(V_LDD, "R7"); push(V_LWB, "R7"); n += 2; end
                4'd10: begin push(V_ST, "R8"); n += 1; next_tag = "R8"; end
                4'd11: if (z) begin push(V_BR, "R9"); n += 1; end else next_tag = "R9";
                4'd12: if (c) begin push(V_BR, "R9"); n += 1; end else next_tag = "R9";
                4'd13: begin push(V_JA, "R10"); n += 1; end
                4'd14: begin push(V_JR, "R10"); n += 1; end
                default: next_tag = "R11";
            endcase
        end
        opcode     = op;
        zero_flag  = z;
        carry_flag = c;
        repeat (n) @(posedge clk);
        #1;
        fetch_tag = next_tag;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        opcode = 4'd0;
        zero_flag = 1'b0;
        carry_flag = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check_word(V_FETCH, "R1");
        rst = 1'b0;

        for (int k = 0; k <= 6; k++) run_instr(4'(k), 1'b0, 1'b0);   // R3 all ALU functions
        run_instr(4'd7, 1'b0, 1'b0);    // R5
        run_instr(4'd8, 1'b0, 1'b0);    // R6
        run_instr(4'd9, 1'b1, 1'b1);    // R7
        run_instr(4'd10, 1'b0, 1'b0);   // R8
        run_instr(4'd11, 1'b1, 1'b0);   // R9 taken on zero
        run_instr(4'd11, 1'b0, 1'b1);   // R9 carry ignored, falls through
        run_instr(4'd12, 1'b0, 1'b1);   // R9 taken on carry
        run_instr(4'd12, 1'b1, 1'b0);   // R9 zero ignored, falls through
        run_instr(4'd13, 1'b0, 1'b0);   // R10
        run_instr(4'd14, 1'b0, 1'b0);   // R10
        run_instr(4'd15, 1'b0, 1'b0);   // R11
        run_instr(4'd2, 1'b1, 1'b1);    // R3 after the unassigned opcode

        // R1: reset arriving during decode of a load
        opcode = 4'd8;
        @(posedge clk);
        #1;
        check_word(V_DEC, "R4");
        rst = 1'b1;
        #1;
        check_word(V_FETCH, "R1");
        @(posedge clk);
        #1;
        check_word(V_FETCH, "R1");
        rst = 1'b0;
        fetch_tag = "R1";
        run_instr(4'd5, 1'b0, 1'b0);
        run_instr(4'd9, 1'b0, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule